// File: doc/BRIEF.md
# Edge/Level Interrupt Pending Controller

This block collects up to 32 interrupt request lines, records which of them are pending and offers one of them at a time to a processor. Each line is fixed at build time as edge-triggered or level-sensitive and as active-high or active-low. Level-sensitive lines report their live, synchronized state as pending. Edge-triggered lines latch an event until software clears it or the processor dispatches that vector.

Software reaches three 32-bit registers through a simple single-cycle write port and a registered read port. The set register sets edge-mode pending flags. The clear register reads back the pending vector and clears edge-mode flags. The mask register enables each source. A global enable input gates every source except one designated non-maskable source. The request output carries the lowest-numbered eligible source. A dispatch-acknowledge pulse carries a vector number and retires that source's edge flag.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, all edge pending flags and all mask bits are 0. With every line at its inactive level, reads of offsets 0x820, 0x824 and 0x828 then return 0, and `irq_req` is 0.
- R2: For a level-mode source, bit i of the value read at 0x820 or 0x824 equals the synchronized active state of line i. For a line set active-low in `ACT_LOW`, a 0 on the pin is active.
- R3: For an edge-mode source, a change of the synchronized line from inactive to active sets bit i of the pending vector. The bit stays set when the line returns to inactive.
- R4: A write to byte offset 0x820 sets the pending flag of every edge-mode source whose data bit is 1. Bits written as 0, and level-mode sources, are left unchanged.
- R5: A read at 0x824 returns the same value as a read at 0x820. A write to 0x824 clears the edge-mode flags whose data bit is 1 and leaves all other bits unchanged.
- R6: If an edge event and a clear write hit the same bit in the same cycle, the bit is set afterwards.
- R7: The mask at 0x828 is read/write. A source whose mask bit is 0 never raises `irq_req`.
- R8: With `glob_en` low, only source `NMI_IDX` can raise `irq_req`.
- R9: `irq_req` and `irq_vec` are registered. One cycle after a set of eligible sources exists, `irq_req` is 1 and `irq_vec` gives the lowest-numbered eligible source. Eligible means pending, unmasked and globally allowed. When no source is eligible, `irq_req` is 0 and `irq_vec` is 0.
- R10: A cycle with `disp_ack` high clears the edge pending flag of source `disp_vec`, unless an edge event on that source occurs in the same cycle.
- R11: Every line passes two synchronizer flops. A level source that becomes active before clock edge k raises `irq_req` at edge k+2, provided it is the only eligible source. Read data is registered: it reflects the address presented one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NSRC | Raw request lines, polarity per `ACT_LOW` |
| glob_en | input | 1 | Global enable for regular sources |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| disp_ack | input | 1 | Dispatch acknowledge pulse |
| disp_vec | input | VEC_W | Vector being dispatched |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | VEC_W | Lowest-numbered eligible source |

## Verification
The assertions assume that `disp_vec` names a source below `NSRC` whenever `disp_ack` is high. They also assume that `bus_wr` and `disp_ack` are low while `rst` is high. The stimulus drives only legal vector numbers and holds both strobes low through reset. All inputs change on the falling clock edge, so every rising edge sees stable values. The directed sequence steps request lines to and from their inactive levels; inactive is high for the active-low lines. Every level and edge event therefore passes cleanly through the synchronizer.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned OFF_SET  = 'h820;
  localparam int unsigned OFF_CLR  = 'h824;
  localparam int unsigned OFF_MASK = 'h828;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_t;
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] ACT_LOW = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] act,
  output logic [N-1:0] rise
);
  logic [N-1:0] s1, s2, prev;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        s1[i] <= ACT_LOW[i];
        s2[i] <= ACT_LOW[i];
        prev[i] <= 1'b0;
      end else begin
        s1[i] <= raw[i];
        s2[i] <= s1[i];
        prev[i] <= act[i];
      end
    end
    assign act[i]  = s2[i] ^ ACT_LOW[i];
    assign rise[i] = act[i] & ~prev[i];
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] EDGE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] act,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pend_view
);
  logic [N-1:0] edge_pend, edge_next;

  always_comb begin
    edge_next = (edge_pend | sw_set) & ~sw_clr & ~ack_clr;
    edge_next = (edge_next | rise) & EDGE;
  end

  always_ff @(posedge clk) begin
    if (rst) edge_pend <= '0;
    else     edge_pend <= edge_next;
  end

  assign pend_view = (edge_pend & EDGE) | (act & ~EDGE);

  // R5
  clear_applies_chk: assert property (@(posedge clk) disable iff (rst)
    (|(sw_clr & ~rise & ~sw_set)) |=> ((edge_pend & $past(sw_clr & ~rise & ~sw_set)) == '0));
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|(sw_clr & rise & EDGE)) |=> ((edge_pend & $past(sw_clr & rise & EDGE)) == $past(sw_clr & rise & EDGE)));
  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ack_clr & ~rise & ~sw_set)) |=> ((edge_pend & $past(ack_clr & ~rise & ~sw_set)) == '0));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N = 32,
  localparam int unsigned VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  elig,
  output logic          req,
  output logic [VW-1:0] vec
);
  logic          hit;
  logic [VW-1:0] idx;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = VW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      vec <= '0;
    end else begin
      req <= hit;
      vec <= idx;
    end
  end

  // R9
  pick_valid_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> (|($past(elig) & (N'(1) << vec))));
  // R9
  pick_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> (($past(elig) & ((N'(1) << vec) - N'(1))) == '0));
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NSRC    = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [NSRC-1:0] EDGE_MODE = 32'hFFFF_FFF0,
  parameter logic [NSRC-1:0] ACT_LOW   = 32'h0000_000F,
  parameter int unsigned NMI_IDX = 4,
  localparam int unsigned VEC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              glob_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              disp_ack,
  input  logic [VEC_W-1:0]  disp_vec,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  localparam logic [NSRC-1:0] NMI_BIT = NSRC'(1) << NMI_IDX;

  logic [NSRC-1:0] act, rise, pend_view, mask_q, elig;
  logic [NSRC-1:0] sw_set, sw_clr, ack_clr;
  reg_sel_t        sel;

  always_comb begin
    if (bus_addr == ADDR_W'(OFF_SET))       sel = SEL_SET;
    else if (bus_addr == ADDR_W'(OFF_CLR))  sel = SEL_CLR;
    else if (bus_addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
    else                                    sel = SEL_NONE;
  end

  assign sw_set  = (bus_wr && sel == SEL_SET) ? bus_wdata[NSRC-1:0] : '0;
  assign sw_clr  = (bus_wr && sel == SEL_CLR) ? bus_wdata[NSRC-1:0] : '0;
  assign ack_clr = disp_ack ? (NSRC'(1) << disp_vec) : '0;

  irq_in_sync #(.N(NSRC), .ACT_LOW(ACT_LOW)) i_sync (
    .clk(clk), .rst(rst), .raw(irq_in), .act(act), .rise(rise)
  );

  irq_pend_bank #(.N(NSRC), .EDGE(EDGE_MODE)) i_bank (
    .clk(clk), .rst(rst), .act(act), .rise(rise),
    .sw_set(sw_set), .sw_clr(sw_clr), .ack_clr(ack_clr),
    .pend_view(pend_view)
  );

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (bus_wr && sel == SEL_MASK) mask_q <= bus_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (sel)
        SEL_SET, SEL_CLR: bus_rdata <= 32'(pend_view);
        SEL_MASK:         bus_rdata <= 32'(mask_q);
        default:          bus_rdata <= '0;
      endcase
    end
  end

  assign elig = pend_view & mask_q & (glob_en ? '1 : NMI_BIT);

  irq_pick #(.N(NSRC)) i_pick (
    .clk(clk), .rst(rst), .elig(elig), .req(irq_req), .vec(irq_vec)
  );

  // R7
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (|($past(mask_q) & (NSRC'(1) << irq_vec))));
  // R8
  nmi_only_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !$past(glob_en)) |-> (irq_vec == VEC_W'(NMI_IDX)));
endmodule

// File: tb/test_irq_pend_ctrl.sv
module test_irq_pend_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam logic [31:0] EM = 32'hFFFF_FFF0;
  localparam logic [31:0] AL = 32'h0000_000F;
  localparam int NMI = 4;

  logic clk = 0, rst = 1;
  logic [31:0] irq_in = AL;
  logic glob_en = 0, bus_wr = 0, disp_ack = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [4:0] disp_vec = '0, irq_vec;
  logic irq_req;
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  irq_pend_ctrl #(.NSRC(N), .ADDR_W(12), .EDGE_MODE(EM), .ACT_LOW(AL), .NMI_IDX(NMI)) i_irq_pend_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .glob_en(glob_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .disp_ack(disp_ack), .disp_vec(disp_vec), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit [31:0] m_s1 = AL, m_s2 = AL, m_prev = 0, m_ep = 0, m_mask = 0, m_rd = 0;
  bit m_req = 0;
  int m_vec = 0;

  always @(posedge clk) begin
    bit [31:0] a, pv, el, nx;
    int v;
    if (rst) begin
      m_s1 <= AL; m_s2 <= AL; m_prev <= 0; m_ep <= 0; m_mask <= 0;
      m_rd <= 0; m_req <= 0; m_vec <= 0;
    end else begin
      a  = m_s2 ^ AL;
      pv = (m_ep & EM) | (a & ~EM);
      if (bus_addr == 12'h820 || bus_addr == 12'h824) m_rd <= pv;
      else if (bus_addr == 12'h828) m_rd <= m_mask;
      else m_rd <= 0;
      el = pv & m_mask;
      if (!glob_en) el = el & (32'd1 << NMI);
      v = 0;
      for (int i = 31; i >= 0; i--) if (el[i]) v = i;
      m_req <= (el != 0);
      m_vec <= v;
      nx = m_ep;
      if (bus_wr && bus_addr == 12'h820) nx = nx | bus_wdata;
      if (bus_wr && bus_addr == 12'h824) nx = nx & ~bus_wdata;
      if (disp_ack) nx[disp_vec] = 1'b0;
      nx = (nx | (a & ~m_prev)) & EM;
      m_ep <= nx;
      m_prev <= a;
      m_s1 <= irq_in;
      m_s2 <= m_s1;
      if (bus_wr && bus_addr == 12'h828) m_mask <= bus_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R9 model irq_req", 32'(irq_req), 32'(m_req));
      chk("R9 model irq_vec", 32'(irq_vec), 32'(m_vec));
      chk("R5 model rdata", bus_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 12'h000;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_addr = 12'h000;
  endtask

  task automatic ack(input int v);
    @(negedge clk); disp_ack = 1; disp_vec = 5'(v);
    @(negedge clk); disp_ack = 0;
  endtask

  initial begin
    logic [31:0] d;
    wait_n(3);
    chk("R1 req in reset", 32'(irq_req), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 req after reset", 32'(irq_req), 0);
    rd(12'h820, d); chk("R1 pending after reset", d, 0);
    rd(12'h824, d); chk("R1 clear after reset", d, 0);
    rd(12'h828, d); chk("R1 mask after reset", d, 0);

    // R2 active-low level line 1
    irq_in[1] = 1'b0; wait_n(4);
    rd(12'h820, d); chk("R2 level active", d, 32'h2);
    irq_in[1] = 1'b1; wait_n(4);
    rd(12'h820, d); chk("R2 level inactive", d, 32'h0);

    // R3 edge pulse on line 8
    @(negedge clk); irq_in[8] = 1'b1;
    @(negedge clk); irq_in[8] = 1'b0;
    wait_n(4);
    rd(12'h820, d); chk("R3 edge latched", d, 32'h100);

    // R4 software set
    wr(12'h820, 32'h0000_0203);
    rd(12'h820, d); chk("R4 set edge only", d, 32'h300);

    // R5 clear reads pending, clear edge bits
    rd(12'h824, d); chk("R5 clear reads pending", d, 32'h300);
    wr(12'h824, 32'h0000_0103);
    rd(12'h824, d); chk("R5 clear applied", d, 32'h200);

    // R7 masked source blocked, then allowed
    glob_en = 1; wait_n(3);
    chk("R7 masked blocked", 32'(irq_req), 0);
    wr(12'h828, 32'h0000_0200);
    rd(12'h828, d); chk("R7 mask readback", d, 32'h200);
    wait_n(2);
    chk("R7 req unmasked", 32'(irq_req), 1);
    chk("R9 vec 9", 32'(irq_vec), 9);

    // R9 priority
    wr(12'h820, 32'h0000_0420);
    wr(12'h828, 32'hFFFF_FFFF);
    wait_n(2);
    chk("R9 lowest vec", 32'(irq_vec), 5);

    // R10 dispatch acknowledge
    ack(5); wait_n(2);
    rd(12'h820, d); chk("R10 ack cleared", d, 32'h600);
    chk("R10 next vec", 32'(irq_vec), 9);

    // R8 global enable and NMI
    glob_en = 0; wait_n(2);
    chk("R8 gated", 32'(irq_req), 0);
    wr(12'h820, 32'h0000_0010); wait_n(2);
    chk("R8 nmi req", 32'(irq_req), 1);
    chk("R8 nmi vec", 32'(irq_vec), 4);
    glob_en = 1; wait_n(2);
    chk("R9 nmi lowest", 32'(irq_vec), 4);
    ack(4);
    wr(12'h824, 32'h0000_0600);
    wr(12'h828, 32'h0);
    rd(12'h820, d); chk("R5 all cleared", d, 0);

    // R6 edge event wins over simultaneous clear
    wr(12'h820, 32'h0000_2000);
    @(negedge clk); irq_in[12] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1; bus_addr = 12'h824; bus_wdata = 32'h0000_3000;
    @(negedge clk); bus_wr = 0; bus_addr = 12'h000;
    rd(12'h820, d); chk("R6 set wins", d, 32'h1000);
    irq_in[12] = 1'b0;
    wr(12'h824, 32'h0000_1000);
    rd(12'h820, d); chk("R6 cleared later", d, 0);

    // R11 synchronizer latency on level line 0
    wr(12'h828, 32'h1);
    wait_n(2);
    @(negedge clk); irq_in[0] = 1'b0;
    @(negedge clk); chk("R11 not yet 1", 32'(irq_req), 0);
    @(negedge clk); chk("R11 not yet 2", 32'(irq_req), 0);
    @(negedge clk); chk("R11 req at +3", 32'(irq_req), 1);
    chk("R11 vec 0", 32'(irq_vec), 0);
    irq_in[0] = 1'b1;
    wait_n(5);
    chk("R2 level drop", 32'(irq_req), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule